// File: doc/BRIEF.md
# Base-Displacement Operand Address Generator

This block sits between instruction fetch and execution. It takes the first six bytes of a fetched instruction and reads a local model of a sixteen-entry, 32-bit general register file. From these it works out the instruction's format and its length in halfwords. It then forms one or two 24-bit storage operand addresses, each the sum of a base register, an optional index register and a 12-bit unsigned displacement. Results are registered and appear with a strobe one cycle after the instruction is presented.

Fixed-size operands must start on a boundary equal to their own size. A misplaced operand raises a specification fault pulse alongside the results instead of a usable address. Variable-length storage-to-storage operands carry a length from the instruction and have no alignment rule. The register file is written through a simple write port that stands in for the execution unit's write-back.

The instruction bus is `instr[47:0]`. The first byte fetched is `instr[47:40]`. Field bit k, counted from the first fetched bit, lives at `instr[47-k]`.

Top module: `oag_addr_gen`

## Requirements
- R1: The two leading opcode bits (`instr[47:46]`) select the format, which is echoed on `o_fmt`. The instruction length code `o_ilc` follows from it: 00 (register-register) gives 1, 01 (register-indexed storage) gives 2, 10 (register-storage or storage-immediate) gives 2, and 11 (storage-storage) gives 3.
- R2: For format 01, `o_ea_a` is computed from three fields. The index selector is `instr[35:32]`, the base selector is `instr[31:28]` and the displacement is `instr[27:16]`. The result is index register plus base register plus displacement, with `o_ea_a_vld` high.
- R3: For format 10, `o_ea_a` is the base register named by `instr[31:28]` plus the displacement in `instr[27:16]`. The bits at `instr[35:32]` never act as an index, whatever register they name.
- R4: For format 11, the first operand address `o_ea_a` is taken from base `instr[31:28]` and displacement `instr[27:16]`. The second operand address `o_ea_b` is taken from base `instr[15:12]` and displacement `instr[11:0]`, and both valid flags are high. `o_oplen` is the byte in `instr[39:32]` plus one, giving 1 to 256. No specification fault is raised, whatever the alignment.
- R5: A base or index selector of zero adds nothing, even when register 0 holds a nonzero value.
- R6: Address sums use the low 24 bits of each register, in two's complement. Any carry out of bit 23 is dropped, so a negative register value subtracts.
- R7: For formats 01 and 10, opcode bits `instr[45:44]` give the fixed operand size, reported on `o_oplen`: code 0 means 1 byte, 1 means 2, 2 means 4 and 3 means 8.
- R8: For formats 01 and 10, `o_spec_fault` pulses with `o_valid` exactly when `o_ea_a` is not a multiple of the operand size. Single-byte operands never fault.
- R9: For format 00, both address outputs are zero, both valid flags are low, `o_oplen` is 0 and no fault is raised. In every format, an operand address that the format does not use reads zero with its valid flag low.
- R10: `o_valid` is high in exactly the cycle after each cycle with `instr_vld` high, including back-to-back instructions. When `instr_vld` is low, the result outputs hold their last values.
- R11: A register write in the same cycle as a decode does not affect that decode. The written value is used from the next decode on.
- R12: After reset, all outputs are zero and all registers read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gpr_we | input | 1 | Register file write enable |
| gpr_waddr | input | 4 | Register written |
| gpr_wdata | input | 32 | Value written |
| instr_vld | input | 1 | Instruction bytes are valid this cycle |
| instr | input | 48 | First six instruction bytes, first byte in the top bits |
| o_valid | output | 1 | Results below were updated this cycle |
| o_fmt | output | 2 | Decoded format |
| o_ilc | output | 2 | Instruction length in halfwords |
| o_ea_a | output | 24 | First storage operand address |
| o_ea_a_vld | output | 1 | `o_ea_a` is meaningful |
| o_ea_b | output | 24 | Second storage operand address |
| o_ea_b_vld | output | 1 | `o_ea_b` is meaningful |
| o_oplen | output | 9 | Operand length in bytes |
| o_spec_fault | output | 1 | Misaligned fixed-size operand |

## Verification
The bench loads register 0 with a nonzero value and then uses zero selectors. A design that reads register 0 there would produce an address that is off by that value. It also stores a value in the register named by the format-10 index field, so a design that treated those bits as an index would add it in. Sums that cross bit 23, and registers with nonzero upper bytes, catch a design that keeps carries or upper bits. A sweep over every size code and every low-address offset catches fault logic with the wrong mask, including a byte operand that faults when it should not. A same-cycle register write followed by a decode exposes a design that forwards the new value into the decode when it must not.

// File: rtl/oag_pkg.sv
package oag_pkg;

  // Format from the two leading opcode bits.
  typedef enum logic [1:0] {
    FMT_RR = 2'b00,
    FMT_RX = 2'b01,
    FMT_RS = 2'b10,
    FMT_SS = 2'b11
  } fmt_e;

  localparam int unsigned LEN_W   = 8;   // storage-storage length byte
  localparam int unsigned OPLEN_W = LEN_W + 1;

  // Instruction length in halfwords.
  function automatic logic [1:0] halfwords_of(fmt_e f);
    case (f)
      FMT_RR:  halfwords_of = 2'd1;
      FMT_SS:  halfwords_of = 2'd3;
      default: halfwords_of = 2'd2;
    endcase
  endfunction

  // Fixed operand size in bytes from the 2-bit size code.
  function automatic logic [3:0] size_bytes(logic [1:0] code);
    size_bytes = 4'd1 << code;
  endfunction

  // True when the low address bits are not a multiple of the size.
  function automatic logic off_boundary(logic [2:0] low, logic [1:0] code);
    logic [3:0] mask;
    mask = size_bytes(code) - 4'd1;
    off_boundary = (low & mask[2:0]) != 3'd0;
  endfunction

endpackage

// File: rtl/oag_gpr.sv
module oag_gpr #(
  parameter int NREG = 16,
  parameter int XLEN = 32,
  parameter int NRD  = 3
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            we,
  input  logic [$clog2(NREG)-1:0]         waddr,
  input  logic [XLEN-1:0]                 wdata,
  input  logic [NRD-1:0][$clog2(NREG)-1:0] raddr,
  output logic [NRD-1:0][XLEN-1:0]        rdata
);
  localparam int RIW = $clog2(NREG);

  logic [XLEN-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       regs[g] <= '0;
      else if (we && waddr == RIW'(g))  regs[g] <= wdata;
    end
  end

  // Reads see the contents before this cycle's write.
  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata[p] = regs[raddr[p]];
  end
endmodule

// File: rtl/oag_decode.sv
module oag_decode
  import oag_pkg::*;
#(
  parameter int INSTR_BYTES = 6,
  parameter int RIW         = 4,
  parameter int DW          = 12
) (
  input  logic [INSTR_BYTES*8-1:0] instr,
  output fmt_e                     fmt,
  output logic [RIW-1:0]           base_a,
  output logic [RIW-1:0]           idx_a,
  output logic [DW-1:0]            disp_a,
  output logic [RIW-1:0]           base_b,
  output logic [DW-1:0]            disp_b,
  output logic                     a_used,
  output logic                     b_used,
  output logic [1:0]               size_code,
  output logic                     align_chk,
  output logic [OPLEN_W-1:0]       oplen
);
  localparam int IW = INSTR_BYTES * 8;

  logic [RIW-1:0]   x_fld;
  logic [LEN_W-1:0] len_fld;
  logic             unused_opbits;

  // Field positions counted from the first fetched bit.
  assign fmt       = fmt_e'(instr[IW-1 -: 2]);
  assign size_code = instr[IW-3 -: 2];
  assign len_fld   = instr[IW-9 -: LEN_W];
  assign x_fld     = instr[IW-13 -: RIW];
  assign base_a    = instr[IW-17 -: RIW];
  assign disp_a    = instr[IW-21 -: DW];
  assign base_b    = instr[IW-33 -: RIW];
  assign disp_b    = instr[IW-37 -: DW];
  assign unused_opbits = ^instr[IW-5 -: 4];

  always_comb begin
    idx_a     = (fmt == FMT_RX) ? x_fld : '0;
    a_used    = (fmt != FMT_RR);
    b_used    = (fmt == FMT_SS);
    align_chk = (fmt == FMT_RX || fmt == FMT_RS) && (size_code != 2'd0);
    case (fmt)
      FMT_RR:  oplen = '0;
      FMT_SS:  oplen = OPLEN_W'(len_fld) + OPLEN_W'(1);
      default: oplen = OPLEN_W'(size_bytes(size_code));
    endcase
  end
endmodule

// File: rtl/oag_ea_unit.sv
module oag_ea_unit #(
  parameter int XLEN = 32,
  parameter int AW   = 24,
  parameter int DW   = 12,
  parameter int RIW  = 4
) (
  input  logic [RIW-1:0]  base_sel,
  input  logic [XLEN-1:0] base_val,
  input  logic [RIW-1:0]  idx_sel,
  input  logic [XLEN-1:0] idx_val,
  input  logic [DW-1:0]   disp,
  output logic [AW-1:0]   ea
);
  logic unused_hi;

  // A zero selector contributes nothing; upper register bits are dropped.
  function automatic logic [AW-1:0] term(logic [RIW-1:0] sel, logic [XLEN-1:0] v);
    term = (sel == '0) ? '0 : v[AW-1:0];
  endfunction

  assign ea        = term(base_sel, base_val) + term(idx_sel, idx_val) + AW'(disp);
  assign unused_hi = ^{base_val[XLEN-1:AW], idx_val[XLEN-1:AW]};
endmodule

// File: rtl/oag_addr_gen.sv
module oag_addr_gen
  import oag_pkg::*;
#(
  parameter int NREG        = 16,
  parameter int XLEN        = 32,
  parameter int AW          = 24,
  parameter int DW          = 12,
  parameter int INSTR_BYTES = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       gpr_we,
  input  logic [$clog2(NREG)-1:0]    gpr_waddr,
  input  logic [XLEN-1:0]            gpr_wdata,
  input  logic                       instr_vld,
  input  logic [INSTR_BYTES*8-1:0]   instr,
  output logic                       o_valid,
  output logic [1:0]                 o_fmt,
  output logic [1:0]                 o_ilc,
  output logic [AW-1:0]              o_ea_a,
  output logic                       o_ea_a_vld,
  output logic [AW-1:0]              o_ea_b,
  output logic                       o_ea_b_vld,
  output logic [OPLEN_W-1:0]         o_oplen,
  output logic                       o_spec_fault
);
  localparam int RIW  = $clog2(NREG);
  localparam int NOP  = 2;          // storage operands per instruction
  localparam int NRD  = 3;          // base A, index A, base B

  fmt_e                        w_fmt;
  logic [RIW-1:0]              w_base_a, w_idx_a, w_base_b;
  logic [DW-1:0]               w_disp_a, w_disp_b;
  logic                        w_a_used, w_b_used, w_align_chk;
  logic [1:0]                  w_size_code;
  logic [OPLEN_W-1:0]          w_oplen;
  logic [NRD-1:0][RIW-1:0]     w_raddr;
  logic [NRD-1:0][XLEN-1:0]    w_rdata;
  logic [NOP-1:0][AW-1:0]      w_ea;
  logic [NOP-1:0][RIW-1:0]     w_bsel, w_isel;
  logic [NOP-1:0][XLEN-1:0]    w_bval, w_ival;
  logic [NOP-1:0][DW-1:0]      w_disp;
  logic                        w_fault_raw;

  oag_decode #(.INSTR_BYTES(INSTR_BYTES), .RIW(RIW), .DW(DW)) i_dec (
    .instr     (instr),
    .fmt       (w_fmt),
    .base_a    (w_base_a),
    .idx_a     (w_idx_a),
    .disp_a    (w_disp_a),
    .base_b    (w_base_b),
    .disp_b    (w_disp_b),
    .a_used    (w_a_used),
    .b_used    (w_b_used),
    .size_code (w_size_code),
    .align_chk (w_align_chk),
    .oplen     (w_oplen)
  );

  assign w_raddr = {w_base_b, w_idx_a, w_base_a};

  oag_gpr #(.NREG(NREG), .XLEN(XLEN), .NRD(NRD)) i_gpr (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (gpr_we),
    .waddr (gpr_waddr),
    .wdata (gpr_wdata),
    .raddr (w_raddr),
    .rdata (w_rdata)
  );

  // Operand A may be indexed; operand B never is.
  assign w_bsel = {w_base_b, w_base_a};
  assign w_bval = {w_rdata[2], w_rdata[0]};
  assign w_isel = {{RIW{1'b0}}, w_idx_a};
  assign w_ival = {{XLEN{1'b0}}, w_rdata[1]};
  assign w_disp = {w_disp_b, w_disp_a};

  for (genvar op = 0; op < NOP; op++) begin : g_ea
    oag_ea_unit #(.XLEN(XLEN), .AW(AW), .DW(DW), .RIW(RIW)) i_ea (
      .base_sel (w_bsel[op]),
      .base_val (w_bval[op]),
      .idx_sel  (w_isel[op]),
      .idx_val  (w_ival[op]),
      .disp     (w_disp[op]),
      .ea       (w_ea[op])
    );
  end

  assign w_fault_raw = w_align_chk && off_boundary(w_ea[0][2:0], w_size_code);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_valid      <= 1'b0;
      o_fmt        <= '0;
      o_ilc        <= '0;
      o_ea_a       <= '0;
      o_ea_a_vld   <= 1'b0;
      o_ea_b       <= '0;
      o_ea_b_vld   <= 1'b0;
      o_oplen      <= '0;
      o_spec_fault <= 1'b0;
    end else begin
      o_valid      <= instr_vld;
      o_spec_fault <= instr_vld && w_fault_raw;
      if (instr_vld) begin
        o_fmt      <= w_fmt;
        o_ilc      <= halfwords_of(w_fmt);
        o_ea_a     <= w_a_used ? w_ea[0] : '0;
        o_ea_a_vld <= w_a_used;
        o_ea_b     <= w_b_used ? w_ea[1] : '0;
        o_ea_b_vld <= w_b_used;
        o_oplen    <= w_oplen;
      end
    end
  end
endmodule

// File: rtl/oag_addr_gen_chk.sv
module oag_addr_gen_chk #(
  parameter int AW = 24,
  parameter int OLW = 9
) (
  input logic           clk,
  input logic           rst_n,
  input logic           instr_vld,
  input logic           o_valid,
  input logic [1:0]     o_fmt,
  input logic [1:0]     o_ilc,
  input logic [AW-1:0]  o_ea_a,
  input logic           o_ea_a_vld,
  input logic           o_ea_b_vld,
  input logic [OLW-1:0] o_oplen,
  input logic           o_spec_fault
);
  logic fixed_fmt;
  logic low_off;
  assign fixed_fmt = (o_fmt == 2'b01) || (o_fmt == 2'b10);
  assign low_off   = (o_ea_a[3:0] & (o_oplen[3:0] - 4'd1)) != 4'd0;

  p_valid_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
    instr_vld |=> o_valid);
  p_valid_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_vld |=> !o_valid);
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_vld |=> $stable(o_ea_a) && $stable(o_oplen) && $stable(o_fmt));
  p_ilc_map_r1: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid |-> o_ilc == ((o_fmt == 2'b00) ? 2'd1 : (o_fmt == 2'b11) ? 2'd3 : 2'd2));
  p_fixed_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && fixed_fmt) |-> ($countones(o_oplen) == 1 && o_oplen <= OLW'(8) && o_ea_a_vld));
  p_fault_ctx_r8: assert property (@(posedge clk) disable iff (!rst_n)
    o_spec_fault |-> (o_valid && fixed_fmt && low_off));
  p_misalign_faults_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && fixed_fmt && low_off) |-> o_spec_fault);
  p_ss_shape_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && o_fmt == 2'b11) |-> (o_ea_a_vld && o_ea_b_vld && !o_spec_fault && o_oplen != '0));
  p_rr_shape_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && o_fmt == 2'b00) |-> (!o_ea_a_vld && !o_ea_b_vld && o_oplen == '0 && !o_spec_fault));
endmodule

bind oag_addr_gen oag_addr_gen_chk #(.AW(AW), .OLW(oag_pkg::OPLEN_W)) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .instr_vld    (instr_vld),
  .o_valid      (o_valid),
  .o_fmt        (o_fmt),
  .o_ilc        (o_ilc),
  .o_ea_a       (o_ea_a),
  .o_ea_a_vld   (o_ea_a_vld),
  .o_ea_b_vld   (o_ea_b_vld),
  .o_oplen      (o_oplen),
  .o_spec_fault (o_spec_fault)
);

// File: tb/test_oag_addr_gen.sv
module test_oag_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        gpr_we = 1'b0;
  logic [3:0]  gpr_waddr = '0;
  logic [31:0] gpr_wdata = '0;
  logic        instr_vld = 1'b0;
  logic [47:0] instr = '0;
  logic        o_valid, o_ea_a_vld, o_ea_b_vld, o_spec_fault;
  logic [1:0]  o_fmt, o_ilc;
  logic [23:0] o_ea_a, o_ea_b;
  logic [8:0]  o_oplen;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  oag_addr_gen i_oag_addr_gen (
    .clk(clk), .rst_n(rst_n), .gpr_we(gpr_we), .gpr_waddr(gpr_waddr),
    .gpr_wdata(gpr_wdata), .instr_vld(instr_vld), .instr(instr),
    .o_valid(o_valid), .o_fmt(o_fmt), .o_ilc(o_ilc), .o_ea_a(o_ea_a),
    .o_ea_a_vld(o_ea_a_vld), .o_ea_b(o_ea_b), .o_ea_b_vld(o_ea_b_vld),
    .o_oplen(o_oplen), .o_spec_fault(o_spec_fault)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic put_reg(input int idx, input logic [31:0] v);
    @(negedge clk);
    gpr_we = 1'b1; gpr_waddr = idx[3:0]; gpr_wdata = v;
    @(negedge clk);
    gpr_we = 1'b0;
  endtask

  task automatic issue(input logic [47:0] ins);
    @(negedge clk);
    instr = ins; instr_vld = 1'b1;
    @(negedge clk);
    instr_vld = 1'b0;
  endtask

  function automatic logic [47:0] mk_rx(input logic [7:0] op, input logic [3:0] r1,
                                        input logic [3:0] x, input logic [3:0] b,
                                        input logic [11:0] d);
    return {op, r1, x, b, d, 16'h0000};
  endfunction

  function automatic logic [47:0] mk_ss(input logic [7:0] op, input logic [7:0] len,
                                        input logic [3:0] b1, input logic [11:0] d1,
                                        input logic [3:0] b2, input logic [11:0] d2);
    return {op, len, b1, d1, b2, d2};
  endfunction

  // Checks a one-operand result (formats 01 and 10).
  task automatic expect_one(input string tag, input int fmt, input int ilc,
                            input logic [23:0] ea, input int flt, input int len);
    chk({tag, " valid"}, o_valid, 1);
    chk({tag, " fmt"}, o_fmt, fmt);
    chk({tag, " ilc"}, o_ilc, ilc);
    chk({tag, " ea_a"}, o_ea_a, ea);
    chk({tag, " ea_a_vld"}, o_ea_a_vld, 1);
    chk({tag, " ea_b R9"}, {o_ea_b_vld, o_ea_b}, 0);
    chk({tag, " fault"}, o_spec_fault, flt);
    chk({tag, " oplen"}, o_oplen, len);
  endtask

  task automatic t_reset;
    chk("R12 valid", o_valid, 0);
    chk("R12 ea_a", o_ea_a, 0);
    chk("R12 ea_b", o_ea_b, 0);
    chk("R12 flags", {o_ea_a_vld, o_ea_b_vld, o_spec_fault}, 0);
    chk("R12 fmt/ilc/oplen", {o_fmt, o_ilc, o_oplen}, 0);
    issue(mk_rx(8'h40, 4'h0, 4'h1, 4'h2, 12'h000));
    chk("R12 regs zero", o_ea_a, 0);
  endtask

  task automatic t_rx_basic;
    issue(mk_rx(8'h60, 4'h3, 4'h2, 4'h1, 12'h004));
    expect_one("R2 rx word", 1, 2, 24'h001204, 0, 4);
    issue(mk_rx(8'h60, 4'h3, 4'h2, 4'h1, 12'h006));
    expect_one("R8 rx word mis", 1, 2, 24'h001206, 1, 4);
    issue(mk_rx(8'h70, 4'h0, 4'h2, 4'h1, 12'h004));
    expect_one("R8 rx dbl mis", 1, 2, 24'h001204, 1, 8);
    issue(mk_rx(8'h70, 4'h0, 4'h2, 4'h1, 12'h008));
    expect_one("R7 rx dbl ok", 1, 2, 24'h001208, 0, 8);
    issue(mk_rx(8'h40, 4'h0, 4'h2, 4'h1, 12'h003));
    expect_one("R8 byte odd no fault", 1, 2, 24'h001203, 0, 1);
    issue(mk_rx(8'h50, 4'h0, 4'h0, 4'h1, 12'h001));
    expect_one("R8 half mis", 1, 2, 24'h001001, 1, 2);
  endtask

  task automatic t_zero_fields;
    issue(mk_rx(8'h40, 4'h0, 4'h0, 4'h0, 12'h123));
    expect_one("R5 both zero", 1, 2, 24'h000123, 0, 1);
    issue(mk_rx(8'h40, 4'h0, 4'h0, 4'h1, 12'h123));
    expect_one("R5 index zero", 1, 2, 24'h001123, 0, 1);
    issue(mk_rx(8'h40, 4'h0, 4'h2, 4'h0, 12'h001));
    expect_one("R5 base zero", 1, 2, 24'h000201, 0, 1);
  endtask

  task automatic t_wrap;
    issue(mk_rx(8'h40, 4'h0, 4'h0, 4'h7, 12'h020));
    expect_one("R6 carry dropped", 1, 2, 24'h000010, 0, 1);
    issue(mk_rx(8'h60, 4'h0, 4'h4, 4'h3, 12'h000));
    expect_one("R6 negative index", 1, 2, 24'hFFFFF8, 0, 4);
  endtask

  task automatic t_rs_si;
    issue({8'h90, 4'h1, 4'h2, 4'h1, 12'h010, 16'h0});
    expect_one("R3 rs index ignored", 2, 2, 24'h001010, 0, 2);
    issue({8'h80, 8'hFF, 4'h0, 12'hFFF, 16'h0});
    expect_one("R3 si imm ignored", 2, 2, 24'h000FFF, 0, 1);
    issue({8'hA0, 4'h1, 4'hF, 4'h1, 12'h002, 16'h0});
    expect_one("R8 rs word mis", 2, 2, 24'h001002, 1, 4);
  endtask

  task automatic t_ss;
    issue(mk_ss(8'hD2, 8'h07, 4'h1, 12'h003, 4'h2, 12'h001));
    chk("R4 valid", o_valid, 1);
    chk("R4 fmt", o_fmt, 3);
    chk("R1 ss ilc", o_ilc, 3);
    chk("R4 ea_a", {o_ea_a_vld, o_ea_a}, {1'b1, 24'h001003});
    chk("R4 ea_b", {o_ea_b_vld, o_ea_b}, {1'b1, 24'h000201});
    chk("R4 oplen", o_oplen, 8);
    chk("R4 no fault", o_spec_fault, 0);
    issue(mk_ss(8'hDC, 8'hFF, 4'h0, 12'h005, 4'h0, 12'hABC));
    chk("R4 len max", o_oplen, 256);
    chk("R5 ss zero bases", {o_ea_a, o_ea_b}, {24'h000005, 24'h000ABC});
    chk("R4 no fault 2", o_spec_fault, 0);
  endtask

  task automatic t_rr;
    issue({8'h1A, 4'h1, 4'h2, 32'h0});
    chk("R1 rr fmt", o_fmt, 0);
    chk("R1 rr ilc", o_ilc, 1);
    chk("R9 rr flags", {o_ea_a_vld, o_ea_b_vld, o_spec_fault}, 0);
    chk("R9 rr addrs", {o_ea_a, o_ea_b}, 0);
    issue({8'h05, 8'h12, 32'hFFFF_FFFF});
    chk("R9 rr junk", {o_ea_a, o_ea_b, o_oplen}, 0);
  endtask

  task automatic t_align_sweep;
    for (int code = 0; code < 4; code++) begin
      for (int off = 0; off < 8; off++) begin
        int sz = 1 << code;
        issue(mk_rx({2'b01, code[1:0], 4'h0}, 4'h0, 4'h0, 4'h1, off[11:0]));
        chk($sformatf("R8 sweep c%0d o%0d", code, off), o_spec_fault, (off % sz) != 0);
        chk($sformatf("R7 sweep c%0d", code), o_oplen, sz);
      end
    end
  endtask

  task automatic t_timing;
    @(negedge clk);
    instr = mk_rx(8'h40, 4'h0, 4'h0, 4'h1, 12'h111); instr_vld = 1'b1;
    @(negedge clk);
    chk("R10 b2b first", {o_valid, o_ea_a}, {1'b1, 24'h001111});
    instr = mk_rx(8'h40, 4'h0, 4'h0, 4'h1, 12'h222);
    @(negedge clk);
    instr_vld = 1'b0;
    instr = mk_rx(8'h40, 4'h0, 4'h0, 4'h1, 12'h333);
    chk("R10 b2b second", {o_valid, o_ea_a}, {1'b1, 24'h001222});
    @(negedge clk);
    chk("R10 idle low", o_valid, 0);
    chk("R10 hold", o_ea_a, 24'h001222);
  endtask

  task automatic t_write_same_cycle;
    @(negedge clk);
    gpr_we = 1'b1; gpr_waddr = 4'h9; gpr_wdata = 32'h0000_3000;
    instr = mk_rx(8'h40, 4'h0, 4'h0, 4'h9, 12'h000); instr_vld = 1'b1;
    @(negedge clk);
    gpr_we = 1'b0; instr_vld = 1'b0;
    chk("R11 old value", o_ea_a, 24'h002000);
    issue(mk_rx(8'h40, 4'h0, 4'h0, 4'h9, 12'h000));
    chk("R11 new value", o_ea_a, 24'h003000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    put_reg(0, 32'h0000_5000);
    put_reg(1, 32'h0000_1000);
    put_reg(2, 32'h0000_0200);
    put_reg(3, 32'hFF00_0008);
    put_reg(4, 32'hFFFF_FFF0);
    put_reg(7, 32'h00FF_FFF0);
    put_reg(9, 32'h0000_2000);
    put_reg(15, 32'h0000_0100);
    t_rx_basic;
    t_zero_fields;
    t_wrap;
    t_rs_si;
    t_ss;
    t_rr;
    t_align_sweep;
    t_timing;
    t_write_same_cycle;
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog R10 act=running exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule